// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block collects interrupt requests from many sources grouped into priority levels, with 32 request slots on each level. A source posts a request with a one-cycle set pulse on its slot. The block holds that request until it is granted. It tells the processor whether any held request outranks the processor's current priority. When the processor acknowledges, the block picks one winning source, clears only that request, and returns the vector stored for that slot.

Software loads the vector for each slot through a simple write port that takes a level, a bit and a 16-bit vector. A device that owns several interrupts normally takes successive slots, with vectors 4 apart. A source with global slot number s sits on level s/32 at bit s mod 32. In the flat request input this is bit position level*32+bit.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `pend_o` is high exactly when some level numerically greater than `cur_prio_i` holds at least one request. Levels at or below `cur_prio_i` never raise it.
- R2: A one-cycle pulse on `req_set_i[level*32+bit]` is held as a request from the next cycle on, until that request is granted.
- R3: `vec_valid_o` is high in the cycle after each cycle in which `ack_i` is high, and low otherwise. `vec_o` changes only in the cycle after an acknowledge.
- R4: On acknowledge, the highest level above `cur_prio_i` that holds a request is chosen. A request on a level at or below `cur_prio_i` is never granted.
- R5: Within the chosen level, the request with the lowest bit number wins.
- R6: A grant clears the winning request and no other held request.
- R7: An acknowledge with no eligible request returns `vec_o` = 0, still pulses `vec_valid_o`, and leaves every held request in place.
- R8: When a set pulse arrives in the same cycle as a grant, a set to another bit is kept alongside the other requests. A set to the granted bit leaves that bit set.
- R9: The vector table resets to all zero. A write with `tbl_we_i` stores `tbl_vec_i` for slot (`tbl_lvl_i`, `tbl_bit_i`). A grant returns the current entry of the winning slot, so a slot that was never written returns 0.
- R10: Slot s of the flat request input maps to level s/32 and bit s mod 32. The vector returned for a grant is the one written at that same level and bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_set_i | input | 256 | Request set pulses, bit level*32+bit |
| cur_prio_i | input | 3 | Current processor priority |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_lvl_i | input | 3 | Vector table write level |
| tbl_bit_i | input | 5 | Vector table write bit |
| tbl_vec_i | input | 16 | Vector value to store |
| pend_o | output | 1 | An eligible request is pending |
| vec_o | output | 16 | Vector of the last acknowledge |
| vec_valid_o | output | 1 | Pulse marking a fresh `vec_o` |

## Verification
A new request can arrive in the same cycle that a grant clears a request. These two functions meet in the request register. The bench provokes this by driving `req_set_i` together with `ack_i`. In one case the set targets the slot being granted; in the other it targets a different bit on the same level. Each case is judged only at the ports. The first acknowledge must return the granted slot's vector. After that, a second acknowledge must return the surviving request's vector, and `pend_o` must drop only once both have been served.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned SLOTS = 32;
  localparam int unsigned BIT_W = $clog2(SLOTS);

  // index of lowest set bit, 0 when none
  function automatic logic [BIT_W-1:0] low_bit(input logic [SLOTS-1:0] w);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (w[i]) r = BIT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_req_store.sv
module irq_req_store import irq_arb_pkg::*; #(
  parameter int NUM_LVL = 8,
  localparam int N = NUM_LVL * SLOTS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] req_q;

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & ~clr_i) | set_i;
  end

  assign req_o = req_q;

  // R6
  one_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i));
  // R2
  set_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((req_q & $past(set_i)) == $past(set_i)));
  // R8
  clear_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((req_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick import irq_arb_pkg::*; #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL),
  localparam int N = NUM_LVL * SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [LVL_W-1:0] prio_i,
  input  logic             grant_en_i,
  output logic             hit_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [N-1:0]     clr_o
);
  logic [NUM_LVL-1:0] elig;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_elig
    assign elig[l] = (|req_i[l*SLOTS +: SLOTS]) && (l > int'(prio_i));
  end

  assign hit_o = |elig;

  always_comb begin
    lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (elig[l]) lvl_o = LVL_W'(l);
    end
  end

  assign bit_o = low_bit(req_i[int'(lvl_o)*SLOTS +: SLOTS]);

  always_comb begin
    clr_o = '0;
    if (grant_en_i && hit_o) clr_o[{lvl_o, bit_o}] = 1'b1;
  end

  // R4
  lvl_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(lvl_o) > int'(prio_i)));
  // R5
  low_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (req_i[{lvl_o, bit_o}] &&
               $countones(req_i[int'(lvl_o)*SLOTS +: SLOTS] &
                          ((32'd1 << bit_o) - 32'd1)) == 0));
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table import irq_arb_pkg::*; #(
  parameter int NUM_LVL = 8,
  parameter int VEC_W = 16,
  localparam int LVL_W = $clog2(NUM_LVL),
  localparam int DEPTH = NUM_LVL * SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic [BIT_W-1:0] wr_bit_i,
  input  logic [VEC_W-1:0] wr_vec_i,
  input  logic [LVL_W-1:0] rd_lvl_i,
  input  logic [BIT_W-1:0] rd_bit_i,
  output logic [VEC_W-1:0] rd_vec_o
);
  logic [VEC_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[{wr_lvl_i, wr_bit_i}] <= wr_vec_i;
    end
  end

  assign rd_vec_o = mem_q[{rd_lvl_i, rd_bit_i}];
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter import irq_arb_pkg::*; #(
  parameter int NUM_LVL = 8,
  parameter int VEC_W = 16,
  localparam int LVL_W = $clog2(NUM_LVL),
  localparam int N = NUM_LVL * SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_set_i,
  input  logic [LVL_W-1:0] cur_prio_i,
  input  logic             ack_i,
  input  logic             tbl_we_i,
  input  logic [LVL_W-1:0] tbl_lvl_i,
  input  logic [BIT_W-1:0] tbl_bit_i,
  input  logic [VEC_W-1:0] tbl_vec_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  logic [N-1:0]     req, clr;
  logic             hit;
  logic [LVL_W-1:0] win_lvl;
  logic [BIT_W-1:0] win_bit;
  logic [VEC_W-1:0] tbl_rd;
  logic [VEC_W-1:0] vec_q;
  logic             vld_q;

  irq_req_store #(.NUM_LVL(NUM_LVL)) u_store (
    .clk_i, .rst_ni, .set_i(req_set_i), .clr_i(clr), .req_o(req)
  );

  irq_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .clk_i, .rst_ni, .req_i(req), .prio_i(cur_prio_i), .grant_en_i(ack_i),
    .hit_o(hit), .lvl_o(win_lvl), .bit_o(win_bit), .clr_o(clr)
  );

  irq_vec_table #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_table (
    .clk_i, .rst_ni, .we_i(tbl_we_i), .wr_lvl_i(tbl_lvl_i),
    .wr_bit_i(tbl_bit_i), .wr_vec_i(tbl_vec_i), .rd_lvl_i(win_lvl),
    .rd_bit_i(win_bit), .rd_vec_o(tbl_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ack_i;
      if (ack_i) vec_q <= hit ? tbl_rd : '0;
    end
  end

  assign pend_o      = hit;
  assign vec_o       = vec_q;
  assign vec_valid_o = vld_q;

  // R3
  ack_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);
  // R3
  no_ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (!vec_valid_o && $stable(vec_o)));
  // R7
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pend_o) |=> (vec_o == '0));
endmodule

// File: tb/tb_irq_vec_arbiter.sv
module tb_irq_vec_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] NONE = 8'hFF;

  // rows: {src_a, src_b, prio, winner slot or NONE}
  localparam int ROWS = 8;
  localparam logic [31:0] TBL [ROWS] = '{
    {8'd229, 8'd97,  8'd2, 8'd229},
    {8'd137, 8'd131, 8'd0, 8'd131},
    {8'd192, 8'd95,  8'd6, NONE},
    {8'd191, 8'd190, 8'd4, 8'd190},
    {8'd39,  8'd66,  8'd1, 8'd66},
    {8'd33,  8'd33,  8'd0, 8'd33},
    {8'd224, 8'd128, 8'd7, NONE},
    {8'd100, 8'd101, 8'd3, NONE}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] req_set = '0;
  logic [2:0]   cur_prio = '0;
  logic         ack = 1'b0;
  logic         tbl_we = 1'b0;
  logic [2:0]   tbl_lvl = '0;
  logic [4:0]   tbl_bit = '0;
  logic [15:0]  tbl_vec = '0;
  logic         pend;
  logic [15:0]  vec;
  logic         vec_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vec_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set), .cur_prio_i(cur_prio),
    .ack_i(ack), .tbl_we_i(tbl_we), .tbl_lvl_i(tbl_lvl), .tbl_bit_i(tbl_bit),
    .tbl_vec_i(tbl_vec), .pend_o(pend), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  function automatic logic [15:0] exp_vec(input int s);
    return 16'h0200 + 16'(4 * s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic post(input logic [255:0] m);
    @(negedge clk); req_set = m;
    @(negedge clk); req_set = '0;
  endtask

  task automatic do_ack(input int prio, input logic [255:0] also);
    @(negedge clk); cur_prio = 3'(prio); ack = 1'b1; req_set = also;
    @(negedge clk); ack = 1'b0; req_set = '0;
  endtask

  task automatic pend_at(input int prio, output logic p);
    cur_prio = 3'(prio);
    #1 p = pend;
  endtask

  task automatic drain();
    int guard = 0;
    cur_prio = 3'd0;
    #1;
    while (pend && guard < 80) begin
      do_ack(0, '0);
      cur_prio = 3'd0;
      #1;
      guard++;
    end
  endtask

  function automatic logic [255:0] bit_of(input int s);
    logic [255:0] m = '0;
    m[s] = 1'b1;
    return m;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset pend", 32'(pend), 0);
    chk("R3 reset valid", 32'(vec_valid), 0);
    chk("R9 reset vec", 32'(vec), 0);
    rst_n = 1'b1;

    // R9: table zero after reset
    post(bit_of(40));
    do_ack(0, '0);
    chk("R9 unwritten after reset", 32'(vec), 0);
    chk("R3 valid after ack", 32'(vec_valid), 1);
    @(negedge clk);
    chk("R3 valid one pulse", 32'(vec_valid), 0);
    pend_at(0, p);
    chk("R6 cleared single", 32'(p), 0);

    // load table for slots 0..254, slot 255 left unwritten
    for (int s = 0; s < 255; s++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_lvl = 3'(s / 32); tbl_bit = 5'(s % 32); tbl_vec = exp_vec(s);
    end
    @(negedge clk); tbl_we = 1'b0;

    // table walk: R4, R5, R7, R10
    for (int r = 0; r < ROWS; r++) begin
      int a = int'(TBL[r][31:24]);
      int b = int'(TBL[r][23:16]);
      int pr = int'(TBL[r][15:8]);
      logic [7:0] w = TBL[r][7:0];
      post(bit_of(a) | bit_of(b));
      pend_at(pr, p);
      chk("R1 row pend", 32'(p), 32'(w != NONE));
      do_ack(pr, '0);
      chk("R4 R5 R10 row vector", 32'(vec), (w == NONE) ? 32'd0 : 32'(exp_vec(int'(w))));
      chk("R7 row valid", 32'(vec_valid), 1);
      drain();
    end

    // R6: exactly one of two on a level cleared
    post(bit_of(70) | bit_of(75));
    do_ack(0, '0);
    chk("R6 first", 32'(vec), 32'(exp_vec(70)));
    pend_at(0, p);
    chk("R6 other kept", 32'(p), 1);
    do_ack(0, '0);
    chk("R6 second", 32'(vec), 32'(exp_vec(75)));
    pend_at(0, p);
    chk("R6 all served", 32'(p), 0);

    // R2 hold and R1 threshold
    post(bit_of(200));
    repeat (5) @(negedge clk);
    pend_at(0, p);
    chk("R2 held", 32'(p), 1);
    pend_at(6, p);
    chk("R1 equal level masked", 32'(p), 0);
    pend_at(5, p);
    chk("R1 level above", 32'(p), 1);
    drain();

    // R7: nothing eligible, request kept
    post(bit_of(180));
    do_ack(6, '0);
    chk("R7 zero vector", 32'(vec), 0);
    chk("R7 valid", 32'(vec_valid), 1);
    pend_at(0, p);
    chk("R7 request kept", 32'(p), 1);
    drain();

    // R8 same bit set during grant
    post(bit_of(150));
    do_ack(0, bit_of(150));
    chk("R8 same grant", 32'(vec), 32'(exp_vec(150)));
    pend_at(0, p);
    chk("R8 same bit stays", 32'(p), 1);
    do_ack(0, '0);
    chk("R8 same regrant", 32'(vec), 32'(exp_vec(150)));
    pend_at(0, p);
    chk("R8 same drained", 32'(p), 0);

    // R8 other bit set during grant
    post(bit_of(150));
    do_ack(0, bit_of(151));
    chk("R8 other grant", 32'(vec), 32'(exp_vec(150)));
    do_ack(0, '0);
    chk("R8 merged", 32'(vec), 32'(exp_vec(151)));
    pend_at(0, p);
    chk("R8 other drained", 32'(p), 0);

    // R9: unwritten slot and rewrite
    post(bit_of(255));
    do_ack(0, '0);
    chk("R9 unwritten slot", 32'(vec), 0);
    chk("R9 unwritten valid", 32'(vec_valid), 1);
    @(negedge clk);
    tbl_we = 1'b1; tbl_lvl = 3'd4; tbl_bit = 5'd3; tbl_vec = 16'hBEEF;
    @(negedge clk); tbl_we = 1'b0;
    post(bit_of(131));
    do_ack(0, '0);
    chk("R9 rewritten entry", 32'(vec), 32'h0000BEEF);

    // R4: level 0 never eligible
    post(bit_of(3));
    pend_at(0, p);
    chk("R4 level zero pend", 32'(p), 0);
    do_ack(0, '0);
    chk("R4 level zero vector", 32'(vec), 0);

    finish_run();
  end
endmodule